// File: doc/BRIEF.md
# Controller Interrupt Status and Enable Block

This block gathers eight event lines from a bus controller into one interrupt output. It also gives software a keyed way to reset the rest of the controller. Each event line sets a sticky bit in a status register when the line rises. Software clears status bits by writing ones to them. An enable register picks which status bits may raise the interrupt. A single global enable bit gates the output as a whole.

A reset register starts a soft-reset sequence, but only when one exact key value is written to it. A two-state machine produces the pulse. In state `SR_IDLE` it waits. The transition *arm* (a write of the key to the reset register) moves it to `SR_PULSE`. It stays in `SR_PULSE` for `RST_LEN` cycles, then takes the transition *expire* back to `SR_IDLE`. While in `SR_PULSE`, the block drives the `soft_rst` output high and holds its own status, enable and global-enable registers at zero.

The register interface is a plain 32-bit write port with a combinational read port. Both share one address.

Top module: `ctl_irq_hub`

## Requirements
- R1: Status bit i (i = 0..7) sets on the clock edge where `src_in[i]` is high and was low at the previous edge. It then stays set while the source stays high or drops. A source held high does not set the bit again after a clear. Bit i always maps to `src_in[i]`. The bits are: 0 arbitration lost, 1 transmit error or message done, 2 transmit FIFO empty, 3 receive FIFO at watermark, 4 bus idle, 5 addressed as slave, 6 no longer addressed as slave, 7 transmit FIFO half empty.
- R2: A write to offset 0x20 clears every status bit whose data bit [7:0] is 1. Status bits written 0 keep their value. A read of 0x20 returns the status in bits [7:0], with zeros above.
- R3: When a status bit gets a clear and a rising source edge in the same cycle, the bit ends up set.
- R4: A write to offset 0x28 loads the enable mask from data bits [7:0]. A read of 0x28 returns it in bits [7:0], with zeros above.
- R5: `irq_out` is high exactly when the global enable is 1 and at least one bit is set in both status and enable. A status bit whose enable is 0 does not raise `irq_out`.
- R6: The global enable is data bit 31 of offset 0x1C. A read of 0x1C returns it in bit 31, with zeros elsewhere. While the global enable is 0, `irq_out` stays low, whatever is pending.
- R7: Writing exactly 0x0000000A to offset 0x40 drives `soft_rst` high for `RST_LEN` (default 4) consecutive cycles, starting with the cycle after the write edge.
- R8: Writing any other value to offset 0x40 gives no `soft_rst` pulse and leaves the status, enable and global-enable registers unchanged.
- R9: A soft reset leaves the status, enable and global-enable registers at zero. Source edges and register writes that happen during the pulse are lost.
- R10: After the hardware reset (`rst_n` low), all registers read 0, and both `irq_out` and `soft_rst` are low. Reads of 0x40, and of any offset not listed above, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 8 | Event lines from the controller; a rising edge on a line sets its status bit |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Interrupt request |
| soft_rst | output | 1 | Soft-reset pulse for the rest of the controller |

## Verification
The bench holds a source high across a clear. A design that sets status on the level instead of the edge would show the bit set again at once. It lines up a clear with a new rising edge on the same bit. A design where the clear wins would lose that event, while a clear on an unrelated bit in the same write must still take effect. It counts the `soft_rst` cycles after the key write, and checks that a non-key write to the reset register leaves the masks intact. An off-by-one pulse counter, or a decode on only the low bits of the key, would show up there. Finally, it toggles the global enable with events pending, and checks that edges arriving during a pulse are lost.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    // Soft-reset sequencer states
    typedef enum logic [0:0] {
        SR_IDLE  = 1'b0,
        SR_PULSE = 1'b1
    } srst_state_t;

endpackage

// File: rtl/irqh_status.sv
module irqh_status #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] status_q
);

    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_in;
        end
    end

    assign rise = src_in & ~src_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (flush) begin
                status_q[i] <= 1'b0;
            end else if (rise[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_q) & ~status_q & ~$past(clr_mask))) |-> $past(flush));

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rise) & ~status_q)) |-> $past(flush));

endmodule

// File: rtl/irqh_softrst.sv
module irqh_softrst
    import irqh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RST_LEN = 4,
    parameter int RST_KEY = 'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              soft_rst
);

    localparam int CNT_W = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_LEN - 1);

    srst_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             key_ok;

    assign key_ok = key_wr && (wdata == DATA_W'(RST_KEY));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SR_IDLE: begin
                if (key_ok) begin
                    state_d = SR_PULSE;
                    cnt_d   = CNT_LAST;
                end
            end
            SR_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = SR_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        soft_rst = (state_q == SR_PULSE);
    end

    // R8
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_ok && state_q == SR_IDLE) |=> !soft_rst);

    // R7
    key_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_ok && state_q == SR_IDLE) |=> soft_rst);

    // R7
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && cnt_q == '0) |=> !soft_rst);

endmodule

// File: rtl/ctl_irq_hub.sv
module ctl_irq_hub #(
    parameter int NSRC     = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int RST_LEN  = 4,
    parameter int GIE_OFS  = 'h1C,
    parameter int STAT_OFS = 'h20,
    parameter int EN_OFS   = 'h28,
    parameter int RST_OFS  = 'h40,
    parameter int RST_KEY  = 'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              soft_rst
);

    localparam int GIE_BIT = DATA_W - 1;
    localparam int PAD_W   = DATA_W - NSRC;

    logic            hit_gie, hit_stat, hit_en, hit_rst;
    logic            wr_live;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] en_q;
    logic            gie_q;

    assign hit_gie  = (reg_addr == ADDR_W'(GIE_OFS));
    assign hit_stat = (reg_addr == ADDR_W'(STAT_OFS));
    assign hit_en   = (reg_addr == ADDR_W'(EN_OFS));
    assign hit_rst  = (reg_addr == ADDR_W'(RST_OFS));
    assign wr_live  = reg_wr && !soft_rst;
    assign clr_mask = (wr_live && hit_stat) ? reg_wdata[NSRC-1:0] : '0;

    irqh_status #(.NSRC(NSRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (soft_rst),
        .src_in   (src_in),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    irqh_softrst #(
        .DATA_W  (DATA_W),
        .RST_LEN (RST_LEN),
        .RST_KEY (RST_KEY)
    ) u_softrst (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (reg_wr && hit_rst),
        .wdata    (reg_wdata),
        .soft_rst (soft_rst)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else if (soft_rst) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else begin
            if (reg_wr && hit_en) begin
                en_q <= reg_wdata[NSRC-1:0];
            end
            if (reg_wr && hit_gie) begin
                gie_q <= reg_wdata[GIE_BIT];
            end
        end
    end

    always_comb begin
        irq_out = gie_q && (|(status_q & en_q));
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_gie) begin
            reg_rdata[GIE_BIT] = gie_q;
        end else if (hit_stat) begin
            reg_rdata = {{PAD_W{1'b0}}, status_q};
        end else if (hit_en) begin
            reg_rdata = {{PAD_W{1'b0}}, en_q};
        end
    end

    // R6
    gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && hit_gie && !reg_wdata[GIE_BIT] && !soft_rst) |-> !irq_out);

    // R5
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|(status_q & en_q)));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst) |-> (status_q == '0 && en_q == '0 && !gie_q));

endmodule

// File: tb/ctl_irq_hub_test.sv
module ctl_irq_hub_test;

    localparam int RST_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_in = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic        soft_rst;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ctl_irq_hub #(.RST_LEN(RST_LEN)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out),
        .soft_rst  (soft_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_src(input int i);
        @(negedge clk); src_in[i] = 1'b1;
        @(negedge clk); src_in[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h20, v); chk("R10 status after reset", v, 0);
        rd(8'h28, v); chk("R10 enable after reset", v, 0);
        rd(8'h1C, v); chk("R10 gie after reset", v, 0);
        rd(8'h40, v); chk("R10 reset reg reads 0", v, 0);
        chk("R10 irq_out low", {31'b0, irq_out}, 0);
        chk("R10 soft_rst low", {31'b0, soft_rst}, 0);
    endtask

    task automatic t_sticky_map();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            pulse_src(i);
            rd(8'h20, v);
            chk("R1 bit map one-hot", v, 32'h1 << i);
            wr(8'h20, 32'hFF);
        end
        @(negedge clk); src_in[0] = 1'b1;
        @(negedge clk);
        rd(8'h20, v); chk("R1 set on rising edge", v, 32'h1);
        wr(8'h20, 32'h1);
        @(negedge clk);
        rd(8'h20, v); chk("R1 level held does not re-set", v, 0);
        src_in[0] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        pulse_src(1); pulse_src(4); pulse_src(6);
        rd(8'h20, v); chk("R2 three bits set", v, 32'h52);
        wr(8'h20, 32'h10);
        rd(8'h20, v); chk("R2 selective clear", v, 32'h42);
        wr(8'h20, 32'h0);
        rd(8'h20, v); chk("R2 zero write keeps bits", v, 32'h42);
        wr(8'h20, 32'hFF);
        rd(8'h20, v); chk("R2 clear all", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse_src(2); pulse_src(3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h0C; src_in[2] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; src_in[2] = 1'b0;
        rd(8'h20, v); chk("R3 set beats same-cycle clear", v, 32'h04);
        wr(8'h20, 32'hFF);
    endtask

    task automatic t_mask_gie();
        logic [31:0] v;
        wr(8'h28, 32'hFFFF_FF81);
        rd(8'h28, v); chk("R4 enable readback", v, 32'h81);
        wr(8'h1C, 32'h8000_0000);
        rd(8'h1C, v); chk("R6 gie readback", v, 32'h8000_0000);
        pulse_src(5);
        chk("R5 masked bit gives no irq", {31'b0, irq_out}, 0);
        pulse_src(7);
        chk("R5 enabled bit raises irq", {31'b0, irq_out}, 1);
        wr(8'h1C, 32'h7FFF_FFFF);
        chk("R6 gie off forces irq low", {31'b0, irq_out}, 0);
        rd(8'h1C, v); chk("R6 gie only bit 31", v, 0);
        wr(8'h1C, 32'h8000_0000);
        chk("R6 gie on restores irq", {31'b0, irq_out}, 1);
        wr(8'h20, 32'h80);
        chk("R5 clear drops irq", {31'b0, irq_out}, 0);
        rd(8'h20, v); chk("R5 masked bit still pending", v, 32'h20);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        logic seen = 1'b0;
        wr(8'h40, 32'h0000_001A);
        for (int k = 0; k < 3; k++) begin
            if (soft_rst) seen = 1'b1;
            @(negedge clk);
        end
        wr(8'h40, 32'h0000_0005);
        for (int k = 0; k < 3; k++) begin
            if (soft_rst) seen = 1'b1;
            @(negedge clk);
        end
        chk("R8 no pulse on wrong key", {31'b0, seen}, 0);
        rd(8'h28, v); chk("R8 enable kept", v, 32'h81);
        rd(8'h1C, v); chk("R8 gie kept", v, 32'h8000_0000);
        rd(8'h20, v); chk("R8 status kept", v, 32'h20);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        int n = 0;
        wr(8'h40, 32'h0000_000A);
        src_in[6] = 1'b1;
        while (soft_rst && n < 20) begin
            n++;
            @(negedge clk);
            if (n == 2) begin
                reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'hFF;
            end else begin
                reg_wr = 1'b0;
            end
        end
        reg_wr = 1'b0;
        chk("R7 pulse length", n, RST_LEN);
        rd(8'h20, v); chk("R9 status cleared, edge during pulse lost", v, 0);
        rd(8'h28, v); chk("R9 enable cleared, write during pulse lost", v, 0);
        rd(8'h1C, v); chk("R9 gie cleared", v, 0);
        chk("R9 irq low after soft reset", {31'b0, irq_out}, 0);
        src_in[6] = 1'b0;
        @(negedge clk);
        rd(8'h30, v); chk("R10 unmapped offset reads 0", v, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky_map();
        t_clear();
        t_set_wins();
        t_mask_gie();
        t_bad_key();
        t_soft_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule